// File: doc/BRIEF.md
# L4 Session Load-Balancer Lookup

This block is one per-packet stage of a switch pipeline that spreads flows across backend servers. For each packet it receives the transport 5-tuple, the current destination IPv4 address and a small vector of chaining metadata flags. It reduces the 5-tuple to a 32-bit CRC and looks that value up in a small table of sessions. The table is matched exactly on the hash.

When the hash is found, the packet's destination address is replaced with the server address held in that session. When the hash is not found, the address is passed through untouched and the send-to-CPU flag is raised, so that the control side can see the packet. The control side then installs a session through the write port and reinjects the packet. From then on, packets of that flow hit the table.

The stage accepts one packet per clock cycle. Every result appears exactly two cycles after its input.

Top module: `l4_session_lb`

## Requirements
- R1: After reset `outValid` is low and every table entry is invalid, so the first lookup misses.
- R2: A packet presented with `inValid` high in cycle k produces `outValid` high in cycle k+2. Packets may be presented on consecutive cycles and come out in the same order, one per cycle.
- R3: The lookup key is CRC32 over 13 bytes taken in this order: `srcIp` (most significant byte first), `dstIp`, `proto`, `srcPort`, `dstPort`. The CRC uses the reflected polynomial 0xEDB88320, processes each byte least significant bit first, starts from all ones and inverts the result.
- R4: On a hit, `outDstIp` equals the stored server address and `outFlags` equals `inFlags`.
- R5: On a miss, `outDstIp` equals the input `dstIp` and `outFlags` equals `inFlags` with bit 4 (send-to-CPU) set. All other flag bits are unchanged.
- R6: A write with `wrEn` high stores `wrValid`, `wrKey` and `wrAddr` into entry `wrIdx`. Writing `wrValid` = 0 clears the entry, and later lookups of its key no longer hit it.
- R7: When several valid entries hold the matching key, the entry with the lowest index supplies the address.
- R8: A write performed in the same cycle as a lookup does not affect that lookup. It takes effect for lookups presented from the next cycle on.
- R9: After a miss, installing the flow's hash and presenting the same packet again yields a hit.
- R10: In a cycle where `outValid` is low, `outDstIp` and `outFlags` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Packet present this cycle |
| srcIp | input | 32 | Source IPv4 address |
| dstIp | input | 32 | Current destination IPv4 address |
| proto | input | 8 | Transport protocol number |
| srcPort | input | 16 | Source transport port |
| dstPort | input | 16 | Destination transport port |
| inFlags | input | FLAG_W (5) | Chaining metadata flags; bit CPU_BIT (4) is send-to-CPU |
| outValid | output | 1 | Result present this cycle |
| outDstIp | output | 32 | Destination address after lookup |
| outFlags | output | FLAG_W (5) | Flags after lookup |
| wrEn | input | 1 | Session table write strobe |
| wrIdx | input | IDX_W (4) | Entry index to write |
| wrKey | input | 32 | Hash key for the entry |
| wrAddr | input | 32 | Server address for the entry |
| wrValid | input | 1 | Valid bit written to the entry |

## Verification
The checker enforces several properties on every cycle. It checks the two-cycle valid latency and that non-CPU flag bits always pass through unchanged. It checks that a packet newly marked for the CPU keeps its destination address, and that the outputs hold while no result is valid. Other behaviours depend on the table contents and the hash, and only the bench's directed scenarios can show them. These are the correctness of the CRC, rewrites on hits, lowest-index priority, clearing an entry, the install-then-reinject sequence and the cycle boundary at which a write becomes visible.

// File: rtl/l4lb_pkg.sv
package l4lb_pkg;

  localparam logic [31:0] CRC_POLY = 32'hEDB88320;

  typedef struct packed {
    logic s1Load;
    logic s2Load;
    logic tblWr;
  } lbStrobes_t;

  function automatic logic [31:0] crc32Key(input logic [103:0] keyBytes);
    logic [31:0] c;
    c = '1;
    for (int b = 12; b >= 0; b--) begin
      c = c ^ {24'd0, keyBytes[b*8 +: 8]};
      for (int k = 0; k < 8; k++) begin
        c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
      end
    end
    return ~c;
  endfunction

endpackage

// File: rtl/lb_ctrl.sv
module lb_ctrl
  import l4lb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       wrEn,
  output lbStrobes_t strobes,
  output logic       outValid
);

  logic s1Valid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      outValid <= 1'b0;
    end else begin
      s1Valid  <= inValid;
      outValid <= s1Valid;
    end
  end

  always_comb begin
    strobes.s1Load = inValid;
    strobes.s2Load = s1Valid;
    strobes.tblWr  = wrEn;
  end

endmodule

// File: rtl/lb_datapath.sv
module lb_datapath
  import l4lb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int FLAG_W  = 5,
  parameter int CPU_BIT = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  lbStrobes_t        strobes,
  input  logic [31:0]       srcIp,
  input  logic [31:0]       dstIp,
  input  logic [7:0]        proto,
  input  logic [15:0]       srcPort,
  input  logic [15:0]       dstPort,
  input  logic [FLAG_W-1:0] inFlags,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [31:0]       wrKey,
  input  logic [31:0]       wrAddr,
  input  logic              wrValid,
  output logic [31:0]       outDstIp,
  output logic [FLAG_W-1:0] outFlags
);

  localparam logic [FLAG_W-1:0] CPU_MASK = FLAG_W'(1) << CPU_BIT;

  logic        entValid [ENTRIES];
  logic [31:0] entKey   [ENTRIES];
  logic [31:0] entAddr  [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entValid[i] <= 1'b0;
        entKey[i]   <= '0;
        entAddr[i]  <= '0;
      end else if (strobes.tblWr && (wrIdx == IDX_W'(i))) begin
        entValid[i] <= wrValid;
        entKey[i]   <= wrKey;
        entAddr[i]  <= wrAddr;
      end
    end
  end

  logic [31:0] flowHash;
  logic        matchHit;
  logic [31:0] matchAddr;

  always_comb begin
    flowHash  = crc32Key({srcIp, dstIp, proto, srcPort, dstPort});
    matchHit  = 1'b0;
    matchAddr = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (entValid[i] && (entKey[i] == flowHash)) begin
        matchHit  = 1'b1;
        matchAddr = entAddr[i];
      end
    end
  end

  logic              s1Hit;
  logic [31:0]       s1Addr;
  logic [31:0]       s1Dst;
  logic [FLAG_W-1:0] s1Flags;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Hit   <= 1'b0;
      s1Addr  <= '0;
      s1Dst   <= '0;
      s1Flags <= '0;
    end else if (strobes.s1Load) begin
      s1Hit   <= matchHit;
      s1Addr  <= matchAddr;
      s1Dst   <= dstIp;
      s1Flags <= inFlags;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outDstIp <= '0;
      outFlags <= '0;
    end else if (strobes.s2Load) begin
      outDstIp <= s1Hit ? s1Addr : s1Dst;
      outFlags <= s1Hit ? s1Flags : (s1Flags | CPU_MASK);
    end
  end

endmodule

// File: rtl/l4_session_lb.sv
module l4_session_lb
  import l4lb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int FLAG_W  = 5,
  parameter int CPU_BIT = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [31:0]       srcIp,
  input  logic [31:0]       dstIp,
  input  logic [7:0]        proto,
  input  logic [15:0]       srcPort,
  input  logic [15:0]       dstPort,
  input  logic [FLAG_W-1:0] inFlags,
  output logic              outValid,
  output logic [31:0]       outDstIp,
  output logic [FLAG_W-1:0] outFlags,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [31:0]       wrKey,
  input  logic [31:0]       wrAddr,
  input  logic              wrValid
);

  lbStrobes_t strobes;

  lb_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .wrEn     (wrEn),
    .strobes  (strobes),
    .outValid (outValid)
  );

  lb_datapath #(
    .ENTRIES (ENTRIES),
    .FLAG_W  (FLAG_W),
    .CPU_BIT (CPU_BIT)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .srcIp    (srcIp),
    .dstIp    (dstIp),
    .proto    (proto),
    .srcPort  (srcPort),
    .dstPort  (dstPort),
    .inFlags  (inFlags),
    .wrIdx    (wrIdx),
    .wrKey    (wrKey),
    .wrAddr   (wrAddr),
    .wrValid  (wrValid),
    .outDstIp (outDstIp),
    .outFlags (outFlags)
  );

endmodule

// File: rtl/l4_session_lb_chk.sv
module l4_session_lb_chk #(
  parameter int FLAG_W  = 5,
  parameter int CPU_BIT = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [31:0]       dstIp,
  input logic [FLAG_W-1:0] inFlags,
  input logic              outValid,
  input logic [31:0]       outDstIp,
  input logic [FLAG_W-1:0] outFlags
);

  localparam logic [FLAG_W-1:0] KEEP_MASK = ~(FLAG_W'(1) << CPU_BIT);

  logic [1:0] warmCnt;
  logic       warm;

  always_ff @(posedge clk) begin
    if (!rstN) warmCnt <= '0;
    else if (warmCnt != 2'd3) warmCnt <= warmCnt + 2'd1;
  end

  assign warm = (warmCnt >= 2'd2);

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##2 outValid);                                         // R2

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> ##2 !outValid);                                       // R2

  AST_FLAGS_PRESERVED: assert property (@(posedge clk) disable iff (!rstN)
    (warm && outValid) |-> ((outFlags & KEEP_MASK) == ($past(inFlags, 2) & KEEP_MASK)));  // R5

  AST_PUNT_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (warm && outValid && outFlags[CPU_BIT] && !$past(inFlags[CPU_BIT], 2))
      |-> (outDstIp == $past(dstIp, 2)));                              // R5

  AST_OUTPUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (warm && !outValid) |-> ($stable(outDstIp) && $stable(outFlags))); // R10

endmodule

bind l4_session_lb l4_session_lb_chk #(
  .FLAG_W  (FLAG_W),
  .CPU_BIT (CPU_BIT)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .dstIp    (dstIp),
  .inFlags  (inFlags),
  .outValid (outValid),
  .outDstIp (outDstIp),
  .outFlags (outFlags)
);

// File: tb/l4_session_lb_tb_top.sv
module l4_session_lb_tb_top;

  localparam int ENTRIES = 16;
  localparam int FLAG_W  = 5;
  localparam int IDX_W   = 4;

  logic              clk = 1'b0;
  logic              rstN;
  logic              inValid;
  logic [31:0]       srcIp, dstIp;
  logic [7:0]        proto;
  logic [15:0]       srcPort, dstPort;
  logic [FLAG_W-1:0] inFlags;
  logic              outValid;
  logic [31:0]       outDstIp;
  logic [FLAG_W-1:0] outFlags;
  logic              wrEn;
  logic [IDX_W-1:0]  wrIdx;
  logic [31:0]       wrKey, wrAddr;
  logic              wrValid;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  l4_session_lb #(.ENTRIES(ENTRIES), .FLAG_W(FLAG_W), .CPU_BIT(4)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcIp(srcIp), .dstIp(dstIp),
    .proto(proto), .srcPort(srcPort), .dstPort(dstPort), .inFlags(inFlags),
    .outValid(outValid), .outDstIp(outDstIp), .outFlags(outFlags),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrKey(wrKey), .wrAddr(wrAddr), .wrValid(wrValid)
  );

  typedef struct {
    logic [31:0] sip, dip;
    logic [7:0]  pr;
    logic [15:0] sp, dp;
    logic [4:0]  fl;
  } flow_t;

  // Independent bit-serial CRC32 model (R3)
  function automatic logic [31:0] refHash(input flow_t f);
    logic [7:0]  bytes [13];
    logic [31:0] c = 32'hFFFFFFFF;
    bytes = '{f.sip[31:24], f.sip[23:16], f.sip[15:8], f.sip[7:0],
              f.dip[31:24], f.dip[23:16], f.dip[15:8], f.dip[7:0],
              f.pr, f.sp[15:8], f.sp[7:0], f.dp[15:8], f.dp[7:0]};
    for (int j = 0; j < 13; j++) begin
      for (int i = 0; i < 8; i++) begin
        logic fb;
        fb = bytes[j][i] ^ c[0];
        c  = {1'b0, c[31:1]};
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return ~c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drivePkt(input flow_t f);
    inValid = 1'b1; srcIp = f.sip; dstIp = f.dip; proto = f.pr;
    srcPort = f.sp; dstPort = f.dp; inFlags = f.fl;
  endtask

  task automatic idle();
    inValid = 1'b0;
  endtask

  task automatic writeEntry(input int idx, input logic [31:0] key,
                            input logic [31:0] addr, input logic vld);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = IDX_W'(idx); wrKey = key; wrAddr = addr; wrValid = vld;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // One packet, result checked two cycles later
  task automatic lookup(input string req, input flow_t f, input logic hit,
                        input logic [31:0] addr);
    @(negedge clk); drivePkt(f);
    @(negedge clk); idle();
    @(negedge clk);
    check(req, {31'd0, outValid}, 32'd1);
    check(req, outDstIp, hit ? addr : f.dip);
    check(req, {27'd0, outFlags}, {27'd0, hit ? f.fl : (f.fl | 5'b10000)});
  endtask

  function automatic flow_t mkFlow(input int n, input logic [4:0] fl);
    flow_t f;
    f.sip = 32'h0A000001 + n; f.dip = 32'hC0A80164; f.pr = 8'd6;
    f.sp = 16'd40000 + 16'(n); f.dp = 16'd443; f.fl = fl;
    return f;
  endfunction

  task automatic t_reset();
    check("R1 outValid after reset", {31'd0, outValid}, 32'd0);
    lookup("R1 empty table misses", mkFlow(0, 5'b00001), 1'b0, 32'd0);
  endtask

  task automatic t_hit();
    flow_t f = mkFlow(1, 5'b00110);
    writeEntry(3, refHash(f), 32'h0A640001, 1'b1);
    lookup("R4 R3 hit rewrites address", f, 1'b1, 32'h0A640001);
  endtask

  task automatic t_miss_install();
    flow_t f = mkFlow(2, 5'b01001);
    lookup("R5 miss punts to CPU", f, 1'b0, 32'd0);
    writeEntry(9, refHash(f), 32'h0A640009, 1'b1);
    lookup("R9 reinjected packet hits", f, 1'b1, 32'h0A640009);
  endtask

  task automatic t_priority_clear();
    flow_t f = mkFlow(3, 5'b00000);
    writeEntry(7, refHash(f), 32'h0A640007, 1'b1);
    writeEntry(2, refHash(f), 32'h0A640002, 1'b1);
    lookup("R7 lowest index wins", f, 1'b1, 32'h0A640002);
    writeEntry(2, refHash(f), 32'h0A640002, 1'b0);
    lookup("R6 cleared entry falls back", f, 1'b1, 32'h0A640007);
    writeEntry(7, 32'd0, 32'd0, 1'b0);
    lookup("R6 cleared entry misses", f, 1'b0, 32'd0);
  endtask

  task automatic t_same_cycle();
    flow_t f = mkFlow(4, 5'b00010);
    @(negedge clk);
    drivePkt(f);
    wrEn = 1'b1; wrIdx = 4'd12; wrKey = refHash(f); wrAddr = 32'h0A64000C; wrValid = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; drivePkt(f);
    @(negedge clk);
    idle();
    check("R8 same-cycle write not seen", outDstIp, f.dip);
    check("R8 same-cycle write punts", {27'd0, outFlags}, {27'd0, f.fl | 5'b10000});
    @(negedge clk);
    check("R8 next-cycle lookup hits", outDstIp, 32'h0A64000C);
    check("R8 next-cycle flags", {27'd0, outFlags}, {27'd0, f.fl});
  endtask

  task automatic t_back_to_back();
    flow_t p [3];
    logic  h [3];
    p[0] = mkFlow(1, 5'b00001); h[0] = 1'b1;  // installed at 3
    p[1] = mkFlow(5, 5'b00100); h[1] = 1'b0;
    p[2] = mkFlow(2, 5'b00000); h[2] = 1'b1;  // installed at 9
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check("R2 pipelined valid", {31'd0, outValid}, 32'd1);
        check("R2 pipelined address", outDstIp,
              h[i-2] ? ((i == 2) ? 32'h0A640001 : 32'h0A640009) : p[i-2].dip);
      end else begin
        check("R2 no early valid", {31'd0, outValid}, 32'd0);
      end
      if (i < 3) drivePkt(p[i]); else idle();
    end
    @(negedge clk);
    check("R10 idle valid low", {31'd0, outValid}, 32'd0);
    check("R10 address held", outDstIp, 32'h0A640009);
    check("R10 flags held", {27'd0, outFlags}, 32'd0);
  endtask

  initial begin
    rstN = 1'b0; inValid = 1'b0; srcIp = '0; dstIp = '0; proto = '0;
    srcPort = '0; dstPort = '0; inFlags = '0;
    wrEn = 1'b0; wrIdx = '0; wrKey = '0; wrAddr = '0; wrValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_hit();
    t_miss_install();
    t_priority_clear();
    t_same_cycle();
    t_back_to_back();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule